// File: doc/BRIEF.md
# Bus-to-SRAM Slave Bridge

This block sits on a single-cycle Wishbone classic bus as a slave and turns each bus transfer into exactly one access on a word-addressed synchronous SRAM port. A USB function core uses it to reach its registers and packet buffers. The bus side carries a byte address, a 32-bit write word, one lane-select bit per byte, a direction bit, and the cycle and strobe qualifiers. It answers with read data and a single-cycle acknowledge.

The slave sees a request in the cycle after the master raises cycle and strobe, and acknowledges at the next clock edge. The transfer completes at the edge where cycle, strobe and acknowledge are all high. Reads are issued to the SRAM in the request cycle, so the registered read data arrives in the acknowledge cycle. Writes are committed only in the acknowledge cycle, so a master that withdraws its request early leaves memory untouched. The SRAM word index is the byte address with its two low bits dropped. Write data and direction pass through unchanged.

Top module: `wb_sram_bridge`

## Requirements
- R1: While the synchronous, active-high reset is high, acknowledge stays low and no SRAM access is made, even with cycle and strobe high.
- R2: When cycle and strobe are both high in a cycle after an idle or completed cycle, acknowledge is high in the next cycle, provided both are still high.
- R3: Acknowledge is never high in a cycle where cycle or strobe is low.
- R4: Acknowledge is a one-cycle pulse. A master that holds its request across an acknowledge edge gets the next acknowledge two cycles later, never in the cycle right after.
- R5: The SRAM word address is the bus byte address shifted right by two. Byte-address bits [1:0] have no effect on which word is accessed.
- R6: A write (direction bit 1) makes exactly one SRAM write, in the acknowledge cycle. The per-byte write mask equals the lane selects (bit i covers data bits 8i+7..8i), and the write word is forwarded unchanged, so only selected lanes change in memory.
- R7: During a read acknowledge, the bus read data is the addressed SRAM word with unselected lanes forced to zero. Outside a read acknowledge, the bus read data is zero.
- R8: If cycle or strobe falls before acknowledge, no acknowledge is given and no SRAM write occurs. The addressed word keeps its old contents.
- R9: A read (direction bit 0) issues one SRAM read, with the write enable low, in the cycle when the request is first seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_adr_i | input | ADDR_W (12) | Byte address |
| bus_dat_i | input | DATA_W (32) | Write data |
| bus_sel_i | input | DATA_W/8 (4) | Byte-lane selects |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_cyc_i | input | 1 | Cycle in progress |
| bus_stb_i | input | 1 | Transfer strobe |
| bus_dat_o | output | DATA_W (32) | Read data, valid with acknowledge |
| bus_ack_o | output | 1 | Transfer acknowledge |
| mem_en_o | output | 1 | SRAM access enable |
| mem_we_o | output | 1 | SRAM write enable (with mem_en_o) |
| mem_addr_o | output | ADDR_W-2 (10) | SRAM word index |
| mem_be_o | output | DATA_W/8 (4) | SRAM per-byte write mask |
| mem_wdata_o | output | DATA_W (32) | SRAM write data |
| mem_rdata_i | input | DATA_W (32) | SRAM read data, one cycle after a read enable |

## Verification
A stale acknowledge state shows up at the ports within one cycle. It appears as a missing acknowledge, as acknowledges on two cycles in a row, or as an acknowledge after strobe has dropped. A wrong access kind shows up at once as an SRAM write outside an acknowledge cycle, or as a read that was never issued. Address or lane errors are silent until that word is read back, so the bench keeps a shadow memory and checks every read acknowledge against it. A corrupted write therefore surfaces at the first later read of the same word.

// File: rtl/wbsb_pkg.sv
package wbsb_pkg;
  typedef enum logic [1:0] {
    ACC_IDLE  = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2
  } acc_kind_e;
endpackage

// File: rtl/wbsb_handshake.sv
module wbsb_handshake (
  input  logic clk,
  input  logic rst,
  input  logic cyc,
  input  logic stb,
  output logic ack,
  output logic req_new
);
  logic req;
  logic ack_q;

  assign req     = cyc & stb & ~rst;
  assign req_new = req & ~ack_q;
  assign ack     = req & ack_q;

  always_ff @(posedge clk) begin
    if (rst) ack_q <= 1'b0;
    else     ack_q <= req & ~ack_q;
  end

  AST_ACK_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    ack |=> !ack); // R4
  AST_ACK_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (rst)
    req_new |=> (ack || !(cyc && stb))); // R2
endmodule

// File: rtl/wbsb_access.sv
module wbsb_access
  import wbsb_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int SEL_W  = DATA_W / 8,
  parameter int WORD_AW = ADDR_W - 2
) (
  input  logic [ADDR_W-1:0]  adr,
  input  logic [DATA_W-1:0]  wdat,
  input  logic [SEL_W-1:0]   sel,
  input  logic               we,
  input  logic               req_new,
  input  logic               ack,
  input  logic [DATA_W-1:0]  mem_rdata,
  output logic               mem_en,
  output logic               mem_we,
  output logic [WORD_AW-1:0] mem_addr,
  output logic [SEL_W-1:0]   mem_be,
  output logic [DATA_W-1:0]  mem_wdata,
  output logic [DATA_W-1:0]  rdata
);
  localparam int OFS = ADDR_W - WORD_AW;

  function automatic logic [WORD_AW-1:0] word_index(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:OFS];
  endfunction

  function automatic logic [DATA_W-1:0] lane_mask(input logic [SEL_W-1:0] s);
    logic [DATA_W-1:0] m;
    for (int i = 0; i < SEL_W; i++) m[i*8 +: 8] = {8{s[i]}};
    return m;
  endfunction

  acc_kind_e kind;

  always_comb begin
    kind = ACC_IDLE;
    if (ack && we)           kind = ACC_WRITE;
    else if (req_new && !we) kind = ACC_READ;
  end

  assign mem_en    = (kind != ACC_IDLE);
  assign mem_we    = (kind == ACC_WRITE);
  assign mem_addr  = word_index(adr);
  assign mem_be    = (kind == ACC_WRITE) ? sel : '0;
  assign mem_wdata = wdat;
  assign rdata     = (ack && !we) ? (mem_rdata & lane_mask(sel)) : '0;
endmodule

// File: rtl/wb_sram_bridge.sv
module wb_sram_bridge #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  localparam int SEL_W  = DATA_W / 8,
  localparam int WORD_AW = ADDR_W - 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ADDR_W-1:0]  bus_adr_i,
  input  logic [DATA_W-1:0]  bus_dat_i,
  input  logic [SEL_W-1:0]   bus_sel_i,
  input  logic               bus_we_i,
  input  logic               bus_cyc_i,
  input  logic               bus_stb_i,
  output logic [DATA_W-1:0]  bus_dat_o,
  output logic               bus_ack_o,
  output logic               mem_en_o,
  output logic               mem_we_o,
  output logic [WORD_AW-1:0] mem_addr_o,
  output logic [SEL_W-1:0]   mem_be_o,
  output logic [DATA_W-1:0]  mem_wdata_o,
  input  logic [DATA_W-1:0]  mem_rdata_i
);
  logic req_new;

  wbsb_handshake u_hs (
    .clk     (clk),
    .rst     (rst),
    .cyc     (bus_cyc_i),
    .stb     (bus_stb_i),
    .ack     (bus_ack_o),
    .req_new (req_new)
  );

  wbsb_access #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .SEL_W  (SEL_W),
    .WORD_AW(WORD_AW)
  ) u_acc (
    .adr       (bus_adr_i),
    .wdat      (bus_dat_i),
    .sel       (bus_sel_i),
    .we        (bus_we_i),
    .req_new   (req_new),
    .ack       (bus_ack_o),
    .mem_rdata (mem_rdata_i),
    .mem_en    (mem_en_o),
    .mem_we    (mem_we_o),
    .mem_addr  (mem_addr_o),
    .mem_be    (mem_be_o),
    .mem_wdata (mem_wdata_o),
    .rdata     (bus_dat_o)
  );

  AST_WRITE_ON_ACK: assert property (@(posedge clk) disable iff (rst)
    (mem_en_o && mem_we_o) |-> bus_ack_o); // R6
  AST_READ_BEFORE_ACK: assert property (@(posedge clk) disable iff (rst)
    (bus_ack_o && !bus_we_i) |-> $past(mem_en_o && !mem_we_o)); // R9
  AST_ACK_NEEDS_STB: assert property (@(posedge clk) disable iff (rst)
    bus_ack_o |-> (bus_cyc_i && bus_stb_i)); // R3
endmodule

// File: tb/tb_wb_sram_bridge.sv
`timescale 1ns/1ps
module tb_wb_sram_bridge;
  localparam int AW = 12;
  localparam int DW = 32;
  localparam int SW = DW / 8;
  localparam int WAW = AW - 2;
  localparam int DEPTH = 1 << WAW;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst = 1'b1;
  logic [AW-1:0] adr = '0;
  logic [DW-1:0] wdat = '0;
  logic [SW-1:0] sel = '0;
  logic we = 1'b0, cyc = 1'b0, stb = 1'b0;
  logic [DW-1:0] rdat;
  logic ack, m_en, m_we;
  logic [WAW-1:0] m_addr;
  logic [SW-1:0] m_be;
  logic [DW-1:0] m_wdata;
  logic [DW-1:0] m_rdata = '0;

  wb_sram_bridge #(.ADDR_W(AW), .DATA_W(DW)) dut (
    .clk(clk), .rst(rst),
    .bus_adr_i(adr), .bus_dat_i(wdat), .bus_sel_i(sel), .bus_we_i(we),
    .bus_cyc_i(cyc), .bus_stb_i(stb), .bus_dat_o(rdat), .bus_ack_o(ack),
    .mem_en_o(m_en), .mem_we_o(m_we), .mem_addr_o(m_addr), .mem_be_o(m_be),
    .mem_wdata_o(m_wdata), .mem_rdata_i(m_rdata)
  );

  logic [DW-1:0] sram [DEPTH];
  logic [DW-1:0] shadow [DEPTH];
  int checks = 0;
  int fails = 0;
  bit armed = 1'b0;

  initial for (int i = 0; i < DEPTH; i++) begin
    sram[i] = '0;
    shadow[i] = '0;
  end

  always @(posedge clk) if (m_en) begin
    if (m_we) begin
      for (int b = 0; b < SW; b++) if (m_be[b]) sram[m_addr][b*8 +: 8] <= m_wdata[b*8 +: 8];
    end else m_rdata <= sram[m_addr];
  end

  task automatic check(input bit ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [DW-1:0] keep_lanes(input logic [DW-1:0] d, input logic [SW-1:0] s);
    logic [DW-1:0] r = '0;
    for (int b = 0; b < SW; b++) if (s[b]) r[b*8 +: 8] = d[b*8 +: 8];
    return r;
  endfunction

  // reference model, evaluated mid-cycle
  always @(negedge clk) begin
    bit req, eack;
    int w;
    req  = cyc && stb && !rst;
    eack = req && armed;
    w    = int'(adr) / 4;
    if (rst) begin
      check(!ack, "R1 ack in reset", {31'b0, ack}, 0);
      check(!m_en, "R1 sram idle in reset", {31'b0, m_en}, 0);
    end else begin
      check(ack == eack, eack ? "R2 ack" : "R3/R4 no ack", {31'b0, ack}, {31'b0, eack});
    end
    if (eack && we) begin
      check(m_en && m_we, "R6 write strobe", {30'b0, m_en, m_we}, 3);
      check(int'(m_addr) == w, "R5 word index", DW'(m_addr), DW'(w));
      check(m_be == sel, "R6 byte mask", DW'(m_be), DW'(sel));
      check(m_wdata == wdat, "R6 write data", m_wdata, wdat);
      for (int b = 0; b < SW; b++) if (sel[b]) shadow[w][b*8 +: 8] = wdat[b*8 +: 8];
    end else begin
      check(!(m_en && m_we), "R8 no stray write", {30'b0, m_en, m_we}, 0);
    end
    if (req && !armed && !we) begin
      check(m_en && !m_we, "R9 read issue", {30'b0, m_en, m_we}, 2);
      check(int'(m_addr) == w, "R5 read index", DW'(m_addr), DW'(w));
    end
    if (eack && !we) check(rdat == keep_lanes(shadow[w], sel), "R7 read data", rdat, keep_lanes(shadow[w], sel));
    else             check(rdat == '0, "R7 idle data", rdat, '0);
    armed = rst ? 1'b0 : (req && !eack);
  end

  task automatic xfer(input bit w_, input logic [AW-1:0] a, input logic [DW-1:0] d,
                      input logic [SW-1:0] s, output logic [DW-1:0] got);
    int n = 0;
    @(posedge clk); #1;
    we = w_; adr = a; wdat = d; sel = s; cyc = 1'b1; stb = 1'b1;
    do begin @(negedge clk); n++; end while (!ack);
    got = rdat;
    check(n == 2, "R2 ack latency", DW'(n), 2);
    @(posedge clk); #1;
    cyc = 1'b0; stb = 1'b0;
  endtask

  logic [DW-1:0] r;

  initial begin
    cyc = 1'b1; stb = 1'b1; we = 1'b1; adr = 12'h010; wdat = 32'hDEAD_BEEF; sel = '1;
    repeat (4) @(posedge clk);
    #1; cyc = 1'b0; stb = 1'b0; rst = 1'b0;
    @(negedge clk);
    check(ack == 1'b0, "R1 ack after reset", {31'b0, ack}, 0);

    // R6/R7 full word write then read
    xfer(1, 12'h020, 32'hA5A5_1234, 4'hF, r);
    xfer(0, 12'h020, 32'h0, 4'hF, r);
    check(r == 32'hA5A5_1234, "R7 readback", r, 32'hA5A5_1234);
    // R1: write during reset must not have landed
    xfer(0, 12'h010, 32'h0, 4'hF, r);
    check(r == 32'h0, "R1 no write in reset", r, 0);

    // R5 low address bits ignored
    xfer(1, 12'h105, 32'h0BAD_F00D, 4'hF, r);
    xfer(0, 12'h104, 32'h0, 4'hF, r);
    check(r == 32'h0BAD_F00D, "R5 aliasing", r, 32'h0BAD_F00D);

    // R6 partial lanes, R7 masked read
    xfer(1, 12'h200, 32'hFFFF_FFFF, 4'hF, r);
    xfer(1, 12'h200, 32'h1234_5678, 4'b0101, r);
    xfer(0, 12'h200, 32'h0, 4'hF, r);
    check(r == 32'hFF34_FF78, "R6 lane write", r, 32'hFF34_FF78);
    xfer(0, 12'h200, 32'h0, 4'b0011, r);
    check(r == 32'h0000_FF78, "R7 lane mask", r, 32'h0000_FF78);

    // R4 held request across ack edge
    @(posedge clk); #1;
    we = 1'b1; adr = 12'h300; wdat = 32'h1111_1111; sel = '1; cyc = 1'b1; stb = 1'b1;
    @(negedge clk); @(negedge clk);
    check(ack == 1'b1, "R4 first ack", {31'b0, ack}, 1);
    @(posedge clk); #1; adr = 12'h304; wdat = 32'h2222_2222;
    @(negedge clk);
    check(ack == 1'b0, "R4 gap after ack", {31'b0, ack}, 0);
    @(negedge clk);
    check(ack == 1'b1, "R4 second ack", {31'b0, ack}, 1);
    @(posedge clk); #1; cyc = 1'b0; stb = 1'b0;
    xfer(0, 12'h304, 32'h0, 4'hF, r);
    check(r == 32'h2222_2222, "R4 second write", r, 32'h2222_2222);

    // R8 abort: strobe withdrawn before ack
    @(posedge clk); #1;
    we = 1'b1; adr = 12'h020; wdat = 32'h7777_7777; sel = '1; cyc = 1'b1; stb = 1'b1;
    @(posedge clk); #1; stb = 1'b0;
    @(negedge clk);
    check(ack == 1'b0, "R8 aborted no ack", {31'b0, ack}, 0);
    @(posedge clk); #1; cyc = 1'b0;
    xfer(0, 12'h020, 32'h0, 4'hF, r);
    check(r == 32'hA5A5_1234, "R8 word unchanged", r, 32'hA5A5_1234);

    // R3 one qualifier only
    @(posedge clk); #1; we = 1'b1; cyc = 1'b1; stb = 1'b0;
    repeat (3) begin @(negedge clk); check(ack == 1'b0, "R3 cyc only", {31'b0, ack}, 0); end
    @(posedge clk); #1; cyc = 1'b0; stb = 1'b1;
    repeat (3) begin @(negedge clk); check(ack == 1'b0, "R3 stb only", {31'b0, ack}, 0); end
    @(posedge clk); #1; stb = 1'b0;

    // mixed traffic
    for (int k = 0; k < 40; k++) begin
      xfer(k % 3 != 0, AW'(k * 52 + 3), DW'(k * 32'h0101_0103), SW'(k + 1), r);
    end
    repeat (3) @(posedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule